// File: doc/BRIEF.md
# Page Program Wrap Buffer

This block gathers the data phase of a page-program command in a serial NOR flash controller. The command front end gives it the 24-bit start address when a program opcode is accepted, then one strobe for each complete data byte, then a close strobe when chip select rises. The close strobe carries a flag that says whether the clock count ended on a byte boundary. Bytes land in a 256-byte page image starting at the offset held in address bits 7..0. The offset advances after each byte and wraps from FFh to 00h inside the same page, so a long burst overwrites its own earliest bytes. A per-byte valid mask records which offsets received data.

A clean close with at least one byte raises a one-cycle commit pulse. The page base, the image and the mask stay frozen for the back end to take. A close in the middle of a byte, or a close with no data byte, raises a one-cycle drop pulse instead. The front end then leaves its write-enable latch set. A combinational merge stage models the back end's bit-clearing program rule. Each valid byte becomes the old page byte ANDed with the new byte. Every other byte passes through unchanged.

Top module: `page_prog_collector`

## Requirements
- R1: After reset, commit_o and drop_o are 0 and mask_o is all zeros.
- R2: A start_i strobe clears every bit of mask_o and sets page_base_o to {addr_i[23:8], 8'h00} on the next cycle.
- R3: Each accepted byte_valid_i is stored at the current offset, starting at addr_i[7:0]. It sets that offset's bit in mask_o (bit i for offset i, data_o bits [8i+7:8i]), and the offset then increments by one.
- R4: After offset FFh the next byte goes to offset 00h of the same page, and page_base_o does not change.
- R5: When more than 256 bytes arrive, each offset holds the most recent byte written to it, and mask_o is all ones.
- R6: Offsets that received no byte since the last start keep their mask bit at 0, and merged_o passes old_data_i through for them.
- R7: end_i with aligned_i=1 after at least one byte makes commit_o 1 for exactly one cycle, the cycle after end_i.
- R8: end_i with aligned_i=0 gives no commit. drop_o is 1 for exactly the one cycle after end_i.
- R9: end_i with no data byte since the start gives drop_o and no commit, whatever the value of aligned_i.
- R10: For an offset whose mask bit is set, merged_o holds old_data_i AND the stored byte.
- R11: byte_valid_i while no program is open (before any start, or after a close) changes neither mask_o nor data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Program opcode accepted; opens a page |
| addr_i | input | 24 | Start address, sampled with start_i |
| byte_valid_i | input | 1 | One complete data byte present |
| byte_i | input | 8 | Data byte |
| end_i | input | 1 | Chip select rose; closes the page |
| aligned_i | input | 1 | Close fell on a byte boundary |
| old_data_i | input | 2048 | Current page contents from the back end |
| commit_o | output | 1 | One-cycle pulse: page is ready to program |
| drop_o | output | 1 | One-cycle pulse: command rejected |
| page_base_o | output | 24 | Page base address, low byte zero |
| data_o | output | 2048 | Page image, byte i at bits [8i+7:8i] |
| mask_o | output | 256 | Per-byte valid mask |
| merged_o | output | 2048 | Old data cleared by the new valid bytes |

## Verification
Bursts are driven from a mid-page offset with few bytes, from an offset near FFh so that they cross the page end, as exactly one full page, as more than a page from a mid offset, and as a single byte at offset FFh. The short burst shows that untouched bytes stay masked off. The crossing burst separates wrapping inside the page from carrying into the next page. The full and overlong bursts show whether the newest bytes win over older ones. Directed cases close mid-byte and with no data byte, send bytes outside a program, and restart after a commit. These tell a real commit apart from a rejected command, and show whether the mask is cleared by the opcode.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned OFF_W  = 8;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CLOSE_NONE   = 2'd0,
    CLOSE_COMMIT = 2'd1,
    CLOSE_DROP   = 2'd2
  } close_e;
endpackage

// File: rtl/ppw_ptr.sv
module ppw_ptr #(
  parameter int unsigned ADDR_W = ppw_pkg::ADDR_W,
  parameter int unsigned OFF_W  = ppw_pkg::OFF_W,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic              end_i,
  input  logic              aligned_i,
  output logic              active_o,
  output logic              clr_o,
  output logic              wr_en_o,
  output logic [OFF_W-1:0]  wr_off_o,
  output logic [PAGE_W-1:0] page_o,
  output ppw_pkg::close_e   close_o
);
  logic              active_q, any_q;
  logic [OFF_W-1:0]  off_q;
  logic [PAGE_W-1:0] page_q;
  ppw_pkg::close_e   close_q;

  assign clr_o    = start_i;
  // start has priority over a byte in the same cycle
  assign wr_en_o  = active_q && byte_valid_i && !start_i;
  assign wr_off_o = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      any_q    <= 1'b0;
      off_q    <= '0;
      page_q   <= '0;
      close_q  <= ppw_pkg::CLOSE_NONE;
    end else begin
      close_q <= ppw_pkg::CLOSE_NONE;
      if (start_i) begin
        active_q <= 1'b1;
        any_q    <= 1'b0;
        off_q    <= addr_i[OFF_W-1:0];
        page_q   <= addr_i[ADDR_W-1:OFF_W];
      end else if (active_q) begin
        if (wr_en_o) begin
          off_q <= off_q + 1'b1;  // natural wrap inside the page
          any_q <= 1'b1;
        end
        if (end_i) begin
          active_q <= 1'b0;
          close_q  <= (aligned_i && (any_q || wr_en_o)) ?
                      ppw_pkg::CLOSE_COMMIT : ppw_pkg::CLOSE_DROP;
        end
      end
    end
  end

  assign active_o = active_q;
  assign page_o   = page_q;
  assign close_o  = close_q;
endmodule

// File: rtl/ppw_store.sv
module ppw_store #(
  parameter int unsigned OFF_W  = ppw_pkg::OFF_W,
  parameter int unsigned BYTE_W = ppw_pkg::BYTE_W,
  localparam int unsigned NBYTES = 1 << OFF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_en_i,
  input  logic [OFF_W-1:0]         wr_off_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic [NBYTES*BYTE_W-1:0] data_o,
  output logic [NBYTES-1:0]        mask_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic              hit;
    logic [BYTE_W-1:0] data_q;
    logic              vld_q;

    assign hit = wr_en_i && (wr_off_i == OFF_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        if (clr_i)    vld_q <= 1'b0;
        else if (hit) vld_q <= 1'b1;
        if (hit)      data_q <= wr_data_i;
      end
    end

    assign data_o[i*BYTE_W +: BYTE_W] = data_q;
    assign mask_o[i] = vld_q;
  end
endmodule

// File: rtl/ppw_merge.sv
module ppw_merge #(
  parameter int unsigned OFF_W  = ppw_pkg::OFF_W,
  parameter int unsigned BYTE_W = ppw_pkg::BYTE_W,
  localparam int unsigned NBYTES = 1 << OFF_W
) (
  input  logic [NBYTES*BYTE_W-1:0] old_i,
  input  logic [NBYTES*BYTE_W-1:0] new_i,
  input  logic [NBYTES-1:0]        mask_i,
  output logic [NBYTES*BYTE_W-1:0] merged_o
);
  // programming only clears bits
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign merged_o[i*BYTE_W +: BYTE_W] = mask_i[i] ?
      (old_i[i*BYTE_W +: BYTE_W] & new_i[i*BYTE_W +: BYTE_W]) :
      old_i[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/page_prog_collector.sv
module page_prog_collector #(
  parameter int unsigned ADDR_W = ppw_pkg::ADDR_W,
  parameter int unsigned OFF_W  = ppw_pkg::OFF_W,
  parameter int unsigned BYTE_W = ppw_pkg::BYTE_W,
  localparam int unsigned NBYTES = 1 << OFF_W,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     byte_valid_i,
  input  logic [BYTE_W-1:0]        byte_i,
  input  logic                     end_i,
  input  logic                     aligned_i,
  input  logic [NBYTES*BYTE_W-1:0] old_data_i,
  output logic                     commit_o,
  output logic                     drop_o,
  output logic [ADDR_W-1:0]        page_base_o,
  output logic [NBYTES*BYTE_W-1:0] data_o,
  output logic [NBYTES-1:0]        mask_o,
  output logic [NBYTES*BYTE_W-1:0] merged_o
);
  logic              active, clr, wr_en;
  logic [OFF_W-1:0]  wr_off;
  logic [PAGE_W-1:0] page;
  ppw_pkg::close_e   close_st;

  ppw_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk_i, .rst_ni, .start_i, .addr_i, .byte_valid_i, .end_i, .aligned_i,
    .active_o(active), .clr_o(clr), .wr_en_o(wr_en), .wr_off_o(wr_off),
    .page_o(page), .close_o(close_st)
  );

  ppw_store #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_store (
    .clk_i, .rst_ni, .clr_i(clr), .wr_en_i(wr_en), .wr_off_i(wr_off),
    .wr_data_i(byte_i), .data_o, .mask_o
  );

  ppw_merge #(.OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_merge (
    .old_i(old_data_i), .new_i(data_o), .mask_i(mask_o), .merged_o
  );

  assign commit_o    = (close_st == ppw_pkg::CLOSE_COMMIT);
  assign drop_o      = (close_st == ppw_pkg::CLOSE_DROP);
  assign page_base_o = {page, {OFF_W{1'b0}}};
endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned OFF_W  = 8,
  localparam int unsigned NBYTES = 1 << OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              byte_valid_i,
  input logic              end_i,
  input logic              aligned_i,
  input logic              active,
  input logic              commit_o,
  input logic              drop_o,
  input logic [NBYTES-1:0] mask_o,
  input logic [ADDR_W-1:0] page_base_o
);
  assert_mask_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> mask_o == '0);

  assert_page_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> page_base_o == {$past(addr_i[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}});

  assert_mask_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (mask_o & $past(mask_o)) == $past(mask_o));

  assert_one_new_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $countones(mask_o & ~$past(mask_o)) <= 1);

  assert_commit_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  assert_commit_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(end_i && aligned_i && active));

  assert_no_both_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && drop_o));

  assert_drop_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !drop_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !start_i) |=> $stable(mask_o));
endmodule

bind page_prog_collector ppw_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
  .byte_valid_i(byte_valid_i), .end_i(end_i), .aligned_i(aligned_i),
  .active(active), .commit_o(commit_o), .drop_o(drop_o),
  .mask_o(mask_o), .page_base_o(page_base_o)
);

// File: tb/tb_page_prog_collector.sv
`timescale 1ns/1ps
module tb_page_prog_collector;
  localparam int NB = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, bv = 0, en = 0, al = 0;
  logic [23:0] addr = '0;
  logic [7:0]  bdat = '0;
  logic [NB*8-1:0] old_d, data, merged;
  logic [NB-1:0]   mask;
  logic [23:0]     pbase;
  logic commit, drop;

  int errors = 0, checks = 0;
  logic [7:0]    exp_buf [NB];
  logic [NB-1:0] exp_mask;
  logic [7:0]    ptr;

  always #2.5 clk = ~clk;

  page_prog_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .byte_valid_i(bv), .byte_i(bdat), .end_i(en), .aligned_i(al),
    .old_data_i(old_d), .commit_o(commit), .drop_o(drop),
    .page_base_o(pbase), .data_o(data), .mask_o(mask), .merged_o(merged)
  );

  // {addr[47:24], nbytes[23:8], seed[7:0]}
  localparam logic [47:0] VEC [5] = '{
    {24'h012340, 16'd4,   8'h10},  // short burst mid page
    {24'h0456FC, 16'd8,   8'h40},  // crosses page end
    {24'hABCD00, 16'd256, 8'h01},  // exactly one page
    {24'h000080, 16'd300, 8'h90},  // overlong
    {24'h1FFFFF, 16'd1,   8'hC3}   // single byte at FFh
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [23:0] a);
    start = 1; addr = a; @(negedge clk); start = 0;
    exp_mask = '0; ptr = a[7:0];
  endtask

  task automatic send(input logic [7:0] b, input bit track);
    bv = 1; bdat = b; @(negedge clk); bv = 0;
    if (track) begin exp_buf[ptr] = b; exp_mask[ptr] = 1'b1; ptr = ptr + 1; end
  endtask

  task automatic close(input bit aligned);
    en = 1; al = aligned; @(negedge clk); en = 0; al = 0;
  endtask

  task automatic check_page(input string tag);
    int bad_d = 0, bad_m = 0;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] o, e;
      o = old_d[i*8 +: 8];
      e = exp_mask[i] ? (o & exp_buf[i]) : o;
      if (exp_mask[i] && data[i*8 +: 8] !== exp_buf[i]) bad_d++;
      if (merged[i*8 +: 8] !== e) bad_m++;
    end
    chk(mask === exp_mask, {tag, " R3 R5 R6 mask"}, mask[63:0], exp_mask[63:0]);
    chk(bad_d == 0, {tag, " R3 R4 R5 data mismatches"}, bad_d, 0);
    chk(bad_m == 0, {tag, " R6 R10 merged mismatches"}, bad_m, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) old_d[i*8 +: 8] = 8'hF0 ^ 8'(i);
    exp_mask = '0;
    repeat (3) @(negedge clk);
    chk(commit === 0 && drop === 0, "R1 pulses idle", {commit, drop}, 0);
    chk(mask === '0, "R1 mask zero", mask[63:0], 0);
    rst_n = 1; @(negedge clk);

    // R11: bytes before any start are ignored
    send(8'h55, 0);
    chk(mask === '0 && data === '0, "R11 byte before start", mask[63:0], 0);

    foreach (VEC[v]) begin
      logic [23:0] a; int n; logic [7:0] s;
      a = VEC[v][47:24]; n = int'(VEC[v][23:8]); s = VEC[v][7:0];
      do_start(a);
      chk(pbase === {a[23:8], 8'h00}, "R2 R4 page base", pbase, {a[23:8], 8'h00});
      for (int k = 0; k < n; k++) send(s + 8'(k * 7), 1);
      chk(pbase === {a[23:8], 8'h00}, "R4 base after burst", pbase, {a[23:8], 8'h00});
      close(1);
      chk(commit === 1 && drop === 0, "R7 commit after clean close", {commit, drop}, 2'b10);
      check_page($sformatf("vec%0d", v));
      @(negedge clk);
      chk(commit === 0, "R7 commit one cycle", commit, 0);
      if (n >= NB) chk(&mask, "R5 mask all ones", mask[63:0], {64{1'b1}});
    end

    // R11: byte after close is ignored
    send(8'h00, 0);
    check_page("after close R11");

    // R2: new start clears mask
    do_start(24'h222210);
    chk(mask === '0, "R2 mask cleared on start", mask[63:0], 0);

    // R8: close mid byte
    send(8'hA1, 1); send(8'hA2, 1); send(8'hA3, 1);
    close(0);
    chk(drop === 1 && commit === 0, "R8 drop on partial byte", {commit, drop}, 2'b01);
    @(negedge clk);
    chk(drop === 0 && commit === 0, "R8 drop one cycle", {commit, drop}, 0);

    // R9: close with no data byte
    do_start(24'h333300);
    close(1);
    chk(drop === 1 && commit === 0, "R9 drop without data", {commit, drop}, 2'b01);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule